// File: doc/BRIEF.md
# Slot Power Mode Controller

This block decides which of the three power switches feeding a removable-card slot conduct and which output discharge devices are engaged. The switches are auxiliary, 3.3 V and 1.5 V. The inputs are a shutdown request, a standby request, two card-present inputs, lockout-good flags for the three supply inputs, per-rail overcurrent flags and a thermal-trip flag. The outputs are one switch enable and one discharge enable per rail, a deglitched active-low overcurrent flag and a mode code for observation.

A seven-state machine holds the slot mode. The states are:

- `ST_OFF`: nothing conducts and nothing discharges.
- `ST_TRIP`: thermal hold.
- `ST_HELD`: the standby request came first, so the slot is kept dark.
- `ST_SHUT`: shutdown, with the outputs discharged.
- `ST_NOCARD`: empty slot, with the outputs discharged.
- `ST_AUX`: only the auxiliary rail is on.
- `ST_ON`: all three rails are on.

The next state is chosen every clock by a fixed priority:

1. Auxiliary lockout moves to `ST_OFF`.
2. Shutdown moves to `ST_SHUT`.
3. Thermal trip moves to `ST_TRIP`.
4. An empty slot moves to `ST_NOCARD`.
5. A standby request moves to `ST_AUX` if the card was powered and the standby-first history bit is clear. Otherwise it moves to `ST_HELD`.
6. A main-supply loss moves to `ST_AUX` from a powered state, and to `ST_OFF` otherwise.
7. In every other case the next state is `ST_ON`.

The standby-first history bit is set while standby is requested with no card in the slot. It clears when standby is released. Every transition takes effect one clock after the inputs that cause it.

The overcurrent flag is filtered on a timebase tick. The flag changes state only after the raw condition (any rail flag set) has disagreed with it for `DEGLITCH_TICKS` consecutive ticks. With a 1 ms tick the default of 20 gives 20 ms.

Top module: `slot_pwr_mode_ctrl`

## Requirements
- R1: The card counts as present when `card_usb_n` or `card_pcie_n` is low. It counts as absent only when both are high.
- R2: With `aux_ok` low, one clock later all switch enables and all discharge enables are 0 and `mode` is 0 (off), whatever the other inputs are.
- R3: With `aux_ok` high and `shdn_n` low, one clock later the switch enables are 000, the discharge enables are 111 and `mode` is 1. This holds regardless of card, standby, supply or thermal inputs.
- R4: With no card present, `aux_ok` high, `shdn_n` high and no thermal trip, the switch enables are 000, the discharge enables are 111 and `mode` is 2.
- R5: When standby (`stby_n` low) arrives while all rails are powered, the switch enables become 001 (bit 0 = auxiliary, bit 1 = 3.3 V, bit 2 = 1.5 V), the discharge enables are 000 and `mode` is 3.
- R6: When standby is requested before the card is present, or before the card has ever been powered, all enables stay 000 and `mode` is 0. Releasing standby then gives full power.
- R7: When `main_ok` or `low_ok` falls after the card was powered, only the auxiliary switch stays on and `mode` is 3. When the supplies are invalid and the card was never powered, everything is off and `mode` is 0.
- R8: With the card present, `shdn_n` high, `stby_n` high, all supplies valid and no thermal trip, the switch enables are 111, the discharge enables are 000 and `mode` is 4.
- R9: A thermal trip (with `aux_ok` and `shdn_n` high) turns all switches and all discharge enables off with `mode` 0. After the trip clears, the normal priority decides the next state.
- R10: `oc_n` goes low once any `oc_hit` bit has been set for `DEGLITCH_TICKS` consecutive `tick` pulses. It returns high after the same number of ticks with no bit set. A shorter excursion either way has no effect, and cycles without `tick` do not count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Timebase pulse for the overcurrent filter |
| shdn_n | input | 1 | Shutdown request, active low |
| stby_n | input | 1 | Standby request, active low |
| card_usb_n | input | 1 | First card-present input, active low |
| card_pcie_n | input | 1 | Second card-present input, active low |
| aux_ok | input | 1 | Auxiliary input above lockout |
| main_ok | input | 1 | 3.3 V input above lockout |
| low_ok | input | 1 | 1.5 V input above lockout |
| oc_hit | input | 3 | Per-rail overcurrent flags (bit 0 aux, 1 3.3 V, 2 1.5 V) |
| therm_trip | input | 1 | Thermal trip flag |
| sw_en | output | 3 | Switch enables (bit 0 aux, 1 3.3 V, 2 1.5 V) |
| dis_en | output | 3 | Discharge enables, same bit order |
| oc_n | output | 1 | Deglitched overcurrent flag, active low |
| mode | output | 3 | 0 off, 1 shutdown, 2 no card, 3 standby/aux only, 4 inserted |

## Verification
The bench first tries each card-present input alone to show that either one counts. It then takes the block through standby after power-up and standby before insertion. Both end with standby held low and the card present, yet only the event order separates auxiliary-only from dark. Main-supply loss is applied once from full power and once from a cold start, which tells the kept-auxiliary case from plain off. Shutdown is applied together with thermal trip, and auxiliary loss together with shutdown, to expose the priority order. The overcurrent filter is driven with a full-length fault, a short clear, a short fault, and a long fault without ticks, which separates tick counting from cycle counting and shows that the counter restarts.

// File: rtl/spmc_pkg.sv
package spmc_pkg;

    localparam int RAILS    = 3;
    localparam int RAIL_AUX = 0;
    localparam int RAIL_V33 = 1;
    localparam int RAIL_V15 = 2;

    typedef enum logic [2:0] {
        ST_OFF    = 3'd0,
        ST_TRIP   = 3'd1,
        ST_HELD   = 3'd2,
        ST_SHUT   = 3'd3,
        ST_NOCARD = 3'd4,
        ST_AUX    = 3'd5,
        ST_ON     = 3'd6
    } spmc_state_e;

    typedef enum logic [2:0] {
        MODE_OFF    = 3'd0,
        MODE_SHUT   = 3'd1,
        MODE_NOCARD = 3'd2,
        MODE_STBY   = 3'd3,
        MODE_ON     = 3'd4
    } spmc_mode_e;

    function automatic logic state_powered(spmc_state_e s);
        return (s == ST_ON) || (s == ST_AUX);
    endfunction

endpackage

// File: rtl/spmc_hist.sv
module spmc_hist (
    input  logic clk,
    input  logic rst_n,
    input  logic stby_n,
    input  logic card,
    output logic hist
);

    // Standby seen while the slot was empty; released with standby.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist <= 1'b0;
        end else begin
            hist <= !stby_n && (hist || !card);
        end
    end

    assert_hist_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stby_n |=> !hist);

    assert_hist_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!stby_n && !card) |=> hist);

endmodule

// File: rtl/spmc_mode_fsm.sv
module spmc_mode_fsm
    import spmc_pkg::*;
#(
    parameter int N_RAIL = RAILS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              aux_ok,
    input  logic              shdn_n,
    input  logic              stby_n,
    input  logic              card,
    input  logic              main_ok,
    input  logic              low_ok,
    input  logic              therm,
    input  logic              hist,
    output logic [N_RAIL-1:0] sw_en,
    output logic [N_RAIL-1:0] dis_en,
    output logic [2:0]        mode
);

    spmc_state_e state;
    spmc_state_e nxt;
    logic        supplies_ok;
    logic        powered;
    logic        all_on;
    logic        aux_only;
    logic        drain;
    spmc_mode_e  mode_e;

    assign supplies_ok = main_ok && low_ok;
    assign powered     = state_powered(state);

    // Next-state priority.
    always_comb begin
        if (!aux_ok) begin
            nxt = ST_OFF;
        end else if (!shdn_n) begin
            nxt = ST_SHUT;
        end else if (therm) begin
            nxt = ST_TRIP;
        end else if (!card) begin
            nxt = ST_NOCARD;
        end else if (!stby_n) begin
            nxt = (powered && !hist) ? ST_AUX : ST_HELD;
        end else if (!supplies_ok) begin
            nxt = powered ? ST_AUX : ST_OFF;
        end else begin
            nxt = ST_ON;
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
        end else begin
            state <= nxt;
        end
    end

    // Output decode from state.
    always_comb begin
        all_on   = 1'b0;
        aux_only = 1'b0;
        drain    = 1'b0;
        mode_e   = MODE_OFF;
        unique case (state)
            ST_OFF, ST_TRIP, ST_HELD: begin
                mode_e = MODE_OFF;
            end
            ST_SHUT: begin
                drain  = 1'b1;
                mode_e = MODE_SHUT;
            end
            ST_NOCARD: begin
                drain  = 1'b1;
                mode_e = MODE_NOCARD;
            end
            ST_AUX: begin
                aux_only = 1'b1;
                mode_e   = MODE_STBY;
            end
            ST_ON: begin
                all_on = 1'b1;
                mode_e = MODE_ON;
            end
            default: begin
                mode_e = MODE_OFF;
            end
        endcase
    end

    generate
        for (genvar r = 0; r < N_RAIL; r++) begin : g_rail
            if (r == RAIL_AUX) begin : g_aux
                assign sw_en[r] = all_on || aux_only;
            end else begin : g_main
                assign sw_en[r] = all_on;
            end
            assign dis_en[r] = drain;
        end
    endgenerate

    assign mode = mode_e;

    assert_aux_lockout_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !aux_ok |=> (sw_en == '0) && (dis_en == '0));

    assert_shutdown_drain_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (aux_ok && !shdn_n) |=> (sw_en == '0) && (dis_en == '1));

    assert_empty_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (aux_ok && shdn_n && !therm && !card) |=> (sw_en == '0) && (dis_en == '1));

    assert_standby_aux_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (aux_ok && shdn_n && !therm && card && !stby_n && !hist && (sw_en == '1))
        |=> (sw_en == N_RAIL'(1)) && (dis_en == '0));

    assert_full_power_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (aux_ok && shdn_n && !therm && card && stby_n && main_ok && low_ok)
        |=> (sw_en == '1) && (dis_en == '0));

    assert_thermal_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (aux_ok && shdn_n && therm) |=> (sw_en == '0) && (dis_en == '0));

endmodule

// File: rtl/spmc_oc_deglitch.sv
module spmc_oc_deglitch #(
    parameter int CH             = 3,
    parameter int DEGLITCH_TICKS = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [CH-1:0] oc_raw,
    output logic          oc_n
);

    localparam int CW = $clog2(DEGLITCH_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(DEGLITCH_TICKS - 1);

    typedef enum logic {
        OC_CLEAR = 1'b0,
        OC_FAULT = 1'b1
    } oc_state_e;

    oc_state_e     st;
    logic [CW-1:0] cnt;
    logic          raw_any;
    logic          differs;

    assign raw_any = |oc_raw;
    assign differs = (st == OC_FAULT) ? !raw_any : raw_any;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= OC_CLEAR;
            cnt <= '0;
        end else if (!differs) begin
            cnt <= '0;
        end else if (tick) begin
            if (cnt == LAST) begin
                cnt <= '0;
                unique case (st)
                    OC_CLEAR: st <= OC_FAULT;
                    OC_FAULT: st <= OC_CLEAR;
                    default:  st <= OC_CLEAR;
                endcase
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign oc_n = (st == OC_CLEAR);

    assert_oc_needs_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(oc_n));

    assert_oc_agree_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_any == !oc_n) |=> $stable(oc_n));

endmodule

// File: rtl/slot_pwr_mode_ctrl.sv
module slot_pwr_mode_ctrl
    import spmc_pkg::*;
#(
    parameter int DEGLITCH_TICKS = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             shdn_n,
    input  logic             stby_n,
    input  logic             card_usb_n,
    input  logic             card_pcie_n,
    input  logic             aux_ok,
    input  logic             main_ok,
    input  logic             low_ok,
    input  logic [RAILS-1:0] oc_hit,
    input  logic             therm_trip,
    output logic [RAILS-1:0] sw_en,
    output logic [RAILS-1:0] dis_en,
    output logic             oc_n,
    output logic [2:0]       mode
);

    logic card;
    logic hist;

    // R1: either presence input low means a card is in the slot.
    assign card = !(card_usb_n && card_pcie_n);

    spmc_hist u_hist (
        .clk    (clk),
        .rst_n  (rst_n),
        .stby_n (stby_n),
        .card   (card),
        .hist   (hist)
    );

    spmc_mode_fsm #(
        .N_RAIL (RAILS)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .aux_ok  (aux_ok),
        .shdn_n  (shdn_n),
        .stby_n  (stby_n),
        .card    (card),
        .main_ok (main_ok),
        .low_ok  (low_ok),
        .therm   (therm_trip),
        .hist    (hist),
        .sw_en   (sw_en),
        .dis_en  (dis_en),
        .mode    (mode)
    );

    spmc_oc_deglitch #(
        .CH             (RAILS),
        .DEGLITCH_TICKS (DEGLITCH_TICKS)
    ) u_oc (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .oc_raw (oc_hit),
        .oc_n   (oc_n)
    );

    assert_rail_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_en & dis_en) == '0);

endmodule

// File: tb/test_slot_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module test_slot_pwr_mode_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       shdn_n = 1'b1;
    logic       stby_n = 1'b1;
    logic       card_usb_n = 1'b1;
    logic       card_pcie_n = 1'b1;
    logic       aux_ok = 1'b0;
    logic       main_ok = 1'b0;
    logic       low_ok = 1'b0;
    logic [2:0] oc_hit = 3'b000;
    logic       therm_trip = 1'b0;
    logic [2:0] sw_en;
    logic [2:0] dis_en;
    logic       oc_n;
    logic [2:0] mode;

    int checks = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [9:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;

    slot_pwr_mode_ctrl #(.DEGLITCH_TICKS(20)) i_slot_pwr_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .tick(tick), .shdn_n(shdn_n), .stby_n(stby_n),
        .card_usb_n(card_usb_n), .card_pcie_n(card_pcie_n), .aux_ok(aux_ok),
        .main_ok(main_ok), .low_ok(low_ok), .oc_hit(oc_hit), .therm_trip(therm_trip),
        .sw_en(sw_en), .dis_en(dis_en), .oc_n(oc_n), .mode(mode)
    );

    // Driver: inputs already set at a falling edge; one rising edge later the
    // expected item is queued for the monitor.
    task automatic step(input logic [2:0] e_sw, input logic [2:0] e_dis,
                        input logic [2:0] e_mode, input logic e_oc, input string tag);
        @(posedge clk);
        exp_q.push_back({e_sw, e_dis, e_mode, e_oc});
        tag_q.push_back(tag);
        @(negedge clk);
    endtask

    // Monitor: compares at the falling edge.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [9:0] e;
            logic [9:0] a;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            a = {sw_en, dis_en, mode, oc_n};
            checks++;
            if (a !== e) begin
                bad++;
                $display("FAIL %s: actual sw=%b dis=%b mode=%0d oc_n=%b expected sw=%b dis=%b mode=%0d oc_n=%b",
                         t, a[9:7], a[6:4], a[3:1], a[0], e[9:7], e[6:4], e[3:1], e[0]);
            end
        end
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            bad++;
            checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step(3'b000, 3'b000, 3'd0, 1'b1, "R2 reset");
        aux_ok = 1;                       step(3'b000, 3'b111, 3'd2, 1'b1, "R4 empty slot");
        main_ok = 1; low_ok = 1;          step(3'b000, 3'b111, 3'd2, 1'b1, "R4 supplies up no card");
        card_usb_n = 0;                   step(3'b111, 3'b000, 3'd4, 1'b1, "R1 R8 first presence input");
        card_usb_n = 1; card_pcie_n = 0;  step(3'b111, 3'b000, 3'd4, 1'b1, "R1 second presence input");
        stby_n = 0;                       step(3'b001, 3'b000, 3'd3, 1'b1, "R5 standby after insertion");
        stby_n = 1;                       step(3'b111, 3'b000, 3'd4, 1'b1, "R8 standby released");
        main_ok = 0;                      step(3'b001, 3'b000, 3'd3, 1'b1, "R7 main drop keeps aux");
        main_ok = 1;                      step(3'b111, 3'b000, 3'd4, 1'b1, "R7 main back");
        shdn_n = 0; therm_trip = 1;       step(3'b000, 3'b111, 3'd1, 1'b1, "R3 shutdown over thermal");
        shdn_n = 1;                       step(3'b000, 3'b000, 3'd0, 1'b1, "R9 thermal hold");
        therm_trip = 0;                   step(3'b111, 3'b000, 3'd4, 1'b1, "R9 thermal recovery");
        card_pcie_n = 1;                  step(3'b000, 3'b111, 3'd2, 1'b1, "R1 both inputs high");
        stby_n = 0;                       step(3'b000, 3'b111, 3'd2, 1'b1, "R4 standby empty slot");
        card_pcie_n = 0;                  step(3'b000, 3'b000, 3'd0, 1'b1, "R6 standby before card");
                                          step(3'b000, 3'b000, 3'd0, 1'b1, "R6 held dark");
        stby_n = 1;                       step(3'b111, 3'b000, 3'd4, 1'b1, "R6 release gives power");
        main_ok = 0; low_ok = 0;          step(3'b001, 3'b000, 3'd3, 1'b1, "R7 both mains drop");
        aux_ok = 0;                       step(3'b000, 3'b000, 3'd0, 1'b1, "R2 aux lockout");
        aux_ok = 1;                       step(3'b000, 3'b000, 3'd0, 1'b1, "R7 never powered off");
        stby_n = 0;                       step(3'b000, 3'b000, 3'd0, 1'b1, "R6 standby before supplies");
        main_ok = 1; low_ok = 1;          step(3'b000, 3'b000, 3'd0, 1'b1, "R6 supplies up still dark");
        stby_n = 1;                       step(3'b111, 3'b000, 3'd4, 1'b1, "R8 full power");
        shdn_n = 0; aux_ok = 0;           step(3'b000, 3'b000, 3'd0, 1'b1, "R2 over shutdown");
        aux_ok = 1;                       step(3'b000, 3'b111, 3'd1, 1'b1, "R3 shutdown");
        shdn_n = 1;                       step(3'b111, 3'b000, 3'd4, 1'b1, "R8 after shutdown");

        // R10: overcurrent filtering
        oc_hit = 3'b010; tick = 1;
        for (int k = 1; k <= 20; k++)
            step(3'b111, 3'b000, 3'd4, (k < 20) ? 1'b1 : 1'b0, "R10 fault entry");
        oc_hit = 3'b000;
        for (int k = 1; k <= 10; k++)
            step(3'b111, 3'b000, 3'd4, 1'b0, "R10 short clear ignored");
        oc_hit = 3'b010;                  step(3'b111, 3'b000, 3'd4, 1'b0, "R10 count restart");
        oc_hit = 3'b000;
        for (int k = 1; k <= 20; k++)
            step(3'b111, 3'b000, 3'd4, (k < 20) ? 1'b0 : 1'b1, "R10 fault exit");
        tick = 0; oc_hit = 3'b100;
        for (int k = 1; k <= 30; k++)
            step(3'b111, 3'b000, 3'd4, 1'b1, "R10 no tick no count");
        tick = 1;
        for (int k = 1; k <= 5; k++)
            step(3'b111, 3'b000, 3'd4, 1'b1, "R10 short fault");
        oc_hit = 3'b000;                  step(3'b111, 3'b000, 3'd4, 1'b1, "R10 glitch ignored");
        tick = 0;

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule